// File: doc/BRIEF.md
# Inactivity Watchdog with Gain Backoff

This block supervises a switching sensor output and its amplifier settings. It counts clock cycles since the last output toggle. When the output has been silent for a full timeout window, it issues a one-cycle re-initialization pulse. The same pulse starts the offset self-calibration. The pulse also forces the amplifier gain code to zero and the gain-trim DAC code to its mid-scale value of binary 100000. While the calibration is running, the block raises a hold enable that freezes the sensor output at its last value. When the calibration engine reports completion, the hold is released and edge-driven switching resumes.

A second, independent supervisor counts output toggles during which no signal peak (maximum or minimum) has been reported. When 16 such toggles accumulate, the gain code is lowered by one step, saturating at zero. This decrement has no other effect. An external gain-raise pulse lets the surrounding gain control step the code upward. The successive-approximation search itself lies outside the block. It is represented only by a start pulse and a done input.

Top module: `inact_watchdog`

## Requirements
- R1: When no qualifying toggle arrives for 2^TIMEOUT_W consecutive clock edges (edges counted after the last toggle, after reset, or after calibration ends), `reinit` is high for exactly the one cycle that follows the 2^TIMEOUT_W-th edge.
- R2: An accepted `out_toggle` restarts the inactivity count from zero, so a further full window of silence is needed before `reinit` fires.
- R3: In the cycle `reinit` is high, `gain_code` reads 0, `trim_code` reads 6'b100000 (decimal 32), `cal_busy` is 1, and `cal_start` is high for that one cycle only.
- R4: `hold_out` equals `cal_busy` at all times. `cal_busy` drops in the cycle after an edge at which `cal_done` is high.
- R5: While `cal_busy` is high, the inactivity count is frozen at zero and `out_toggle` is ignored by both counters, so no `reinit` occurs during calibration and toggles seen then never contribute to a gain decrement.
- R6: The 16th accepted toggle since the last peak, reinit or decrement lowers `gain_code` by 1 in the following cycle, and the toggle count starts again.
- R7: A decrement at `gain_code` = 0 leaves it at 0.
- R8: `peak_found` high at an edge clears the toggle count, including when a toggle arrives in the same cycle, and that toggle is not counted.
- R9: A gain decrement does not pulse `reinit` or `cal_start` and does not change `trim_code` or `cal_busy`.
- R10: A `gain_up` pulse raises `gain_code` by 1, saturating at 15. A raise and a decrement at the same edge leave the code unchanged.
- R11: During and right after reset, `gain_code` = 0, `trim_code` = 32, and `cal_busy`, `hold_out`, `reinit` and `cal_start` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| out_toggle | input | 1 | One-cycle pulse on each sensor output switch |
| peak_found | input | 1 | A new maximum or minimum was found this cycle |
| gain_up | input | 1 | Request to raise the gain code by one step |
| cal_done | input | 1 | Offset self-calibration finished |
| reinit | output | 1 | One-cycle system re-initialization pulse |
| cal_start | output | 1 | One-cycle start of the offset self-calibration |
| gain_code | output | GAIN_W | Amplifier gain code |
| trim_code | output | TRIM_W | Gain-trim DAC code |
| cal_busy | output | 1 | Self-calibration in progress |
| hold_out | output | 1 | Freeze the sensor output at its last value |

## Verification
Every result is registered once. A change caused by a stimulus applied before edge N is visible from the falling edge after edge N. The bench drives inputs at falling edges and samples there, so the cycle each result is due can be counted exactly.

The timeout is checked on both sides of its boundary. After the edge that carries a toggle or ends a calibration, `reinit` must be low at each of the next 2^TIMEOUT_W − 1 samples and high at the next one. The gain backoff is swept arithmetically from 15 down past zero: after every toggle, the expected code is max(0, 15 − ⌊n/16⌋).

// File: rtl/inact_watchdog.sv
module inact_watchdog #(
  parameter int TIMEOUT_W = 20,
  parameter int GAIN_W    = 4,
  parameter int TRIM_W    = 6,
  parameter int EVT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_toggle,
  input  logic              peak_found,
  input  logic              gain_up,
  input  logic              cal_done,
  output logic              reinit,
  output logic              cal_start,
  output logic [GAIN_W-1:0] gain_code,
  output logic [TRIM_W-1:0] trim_code,
  output logic              cal_busy,
  output logic              hold_out
);

  localparam logic [TRIM_W-1:0] TRIM_MID = {1'b1, {(TRIM_W-1){1'b0}}};
  localparam logic [GAIN_W-1:0] GAIN_MAX = '1;

  logic [TIMEOUT_W-1:0] idle_cnt;
  logic [EVT_W-1:0]     evt_cnt;
  logic                 reinit_q, busy_q;
  logic [GAIN_W-1:0]    gain_q;
  logic [TRIM_W-1:0]    trim_q;

  wire tog_ok   = out_toggle && !busy_q;
  wire idle_end = !busy_q && !tog_ok && (idle_cnt == '1);
  wire dec      = tog_ok && !peak_found && (evt_cnt == '1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          idle_cnt <= '0;
    else if (busy_q || tog_ok || idle_end) idle_cnt <= '0;
    else                                 idle_cnt <= idle_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          evt_cnt <= '0;
    else if (idle_end || peak_found)     evt_cnt <= '0;
    else if (tog_ok)                     evt_cnt <= evt_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reinit_q <= 1'b0;
      busy_q   <= 1'b0;
      trim_q   <= TRIM_MID;
    end else begin
      reinit_q <= idle_end;
      if (idle_end) begin
        busy_q <= 1'b1;
        trim_q <= TRIM_MID;
      end else if (busy_q && cal_done) begin
        busy_q <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                          gain_q <= '0;
    else if (idle_end)                                   gain_q <= '0;
    else if (dec && !gain_up && gain_q != '0)            gain_q <= gain_q - 1'b1;
    else if (gain_up && !dec && gain_q != GAIN_MAX)      gain_q <= gain_q + 1'b1;

  assign reinit    = reinit_q;
  assign cal_start = reinit_q;
  assign gain_code = gain_q;
  assign trim_code = trim_q;
  assign cal_busy  = busy_q;
  assign hold_out  = busy_q;

  a_r1_reinit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> !reinit);

  a_r3_reinit_values: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |-> (gain_code == '0 && trim_code == TRIM_MID && cal_busy));

  a_r2_toggle_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (out_toggle && !cal_busy) |=> (idle_cnt == '0 && !reinit));

  a_r4_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && cal_done && !reinit) |=> !cal_busy);

  a_r5_no_reinit_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && !reinit) |=> !reinit);

  a_r8_peak_clears: assert property (@(posedge clk) disable iff (!rst_n)
    peak_found |=> (evt_cnt == '0));

  a_r9_dec_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> (!reinit && $stable(trim_code) && $stable(cal_busy)));

  a_r10_gain_step: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_end |=> (int'(gain_code) - int'($past(gain_code)) <= 1 &&
                   int'($past(gain_code)) - int'(gain_code) <= 1));

  always_comb
    a_r4_hold_mirror: assert (hold_out == cal_busy);

endmodule

// File: tb/inact_watchdog_tb.sv
module inact_watchdog_tb;
  localparam int TW = 5;
  localparam int WIN = 1 << TW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic out_toggle = 0, peak_found = 0, gain_up = 0, cal_done = 0;
  logic reinit, cal_start, cal_busy, hold_out;
  logic [3:0] gain_code;
  logic [5:0] trim_code;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  inact_watchdog #(.TIMEOUT_W(TW), .GAIN_W(4), .TRIM_W(6), .EVT_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .out_toggle(out_toggle), .peak_found(peak_found),
    .gain_up(gain_up), .cal_done(cal_done), .reinit(reinit), .cal_start(cal_start),
    .gain_code(gain_code), .trim_code(trim_code), .cal_busy(cal_busy), .hold_out(hold_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_tog(input bit with_peak, input bit with_up);
    out_toggle = 1; peak_found = with_peak; gain_up = with_up;
    tick();
    out_toggle = 0; peak_found = 0; gain_up = 0;
    tick();
  endtask

  task automatic raise(input int n);
    for (int i = 0; i < n; i++) begin gain_up = 1; tick(); gain_up = 0; end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog timeout");
      finish_run();
    end
  end

  initial begin
    int exp_g;
    repeat (3) tick();
    // R11 reset state
    chk(gain_code == 0 && trim_code == 32 && !cal_busy && !hold_out && !reinit && !cal_start,
        "R11 reset", gain_code, 0);
    rst_n = 1;
    tick();
    chk(gain_code == 0 && trim_code == 32 && !cal_busy && !reinit, "R11 after reset", trim_code, 32);

    // R10 raise with saturation
    raise(20);
    chk(gain_code == 15, "R10 saturate high", gain_code, 15);

    // R6 R7 R9 sweep down past zero
    for (int n = 1; n <= 17 * 16; n++) begin
      pulse_tog(0, 0);
      exp_g = 15 - n / 16;
      if (exp_g < 0) exp_g = 0;
      chk(gain_code == exp_g, (n > 15 * 16) ? "R7 saturate zero" : "R6 decrement", gain_code, exp_g);
      chk(trim_code == 32 && !reinit && !cal_start && !cal_busy, "R9 no side effect", trim_code, 32);
    end

    // R8 peak clears count, including with simultaneous toggle
    raise(3);
    for (int i = 0; i < 15; i++) pulse_tog(0, 0);
    pulse_tog(1, 0);
    for (int i = 0; i < 15; i++) pulse_tog(0, 0);
    chk(gain_code == 3, "R8 peak cleared count", gain_code, 3);
    pulse_tog(0, 0);
    chk(gain_code == 2, "R8 16th after peak", gain_code, 2);
    peak_found = 1; tick(); peak_found = 0; tick();
    for (int i = 0; i < 15; i++) pulse_tog(0, 0);
    chk(gain_code == 2, "R8 standalone peak", gain_code, 2);

    // R10 raise and decrement cancel
    pulse_tog(0, 1);
    chk(gain_code == 2, "R10 cancel", gain_code, 2);

    // R2 R1 R3 timeout
    raise(3);
    pulse_tog(0, 0);
    for (int i = 0; i < WIN - 2; i++) begin
      tick();
      chk(!reinit, "R2 window 1", reinit, 0);
    end
    out_toggle = 1; tick(); out_toggle = 0;
    for (int i = 0; i < WIN - 1; i++) begin
      tick();
      chk(!reinit, "R2 restarted", reinit, 0);
    end
    tick();
    chk(reinit && cal_start, "R1 reinit fires", reinit, 1);
    chk(gain_code == 0 && trim_code == 32 && cal_busy && hold_out, "R3 forced values", gain_code, 0);
    tick();
    chk(!reinit && !cal_start && cal_busy, "R1 one cycle", reinit, 0);

    // R5 toggles ignored, no timeout while busy
    raise(2);
    for (int i = 0; i < 20; i++) pulse_tog(0, 0);
    repeat (2 * WIN) tick();
    chk(!reinit && cal_busy && hold_out, "R5 frozen while busy", reinit, 0);
    chk(gain_code == 2, "R5 toggles not counted", gain_code, 2);
    cal_done = 1; tick(); cal_done = 0;
    chk(!cal_busy && !hold_out, "R4 release", cal_busy, 0);
    for (int i = 0; i < 15; i++) pulse_tog(0, 0);
    chk(gain_code == 2, "R5 count from done", gain_code, 2);
    pulse_tog(0, 0);
    chk(gain_code == 1, "R6 after calibration", gain_code, 1);

    // R1 R4 window measured from end of calibration
    tick();
    chk(reinit == 0, "R1 pre", reinit, 0);
    for (int i = 0; i < WIN - 2; i++) tick();
    chk(reinit && cal_busy, "R1 second timeout", reinit, 1);
    repeat (3) tick();
    cal_done = 1; tick(); cal_done = 0;
    for (int i = 0; i < WIN - 1; i++) begin
      tick();
      chk(!reinit, "R1 window from done", reinit, 0);
    end
    tick();
    chk(reinit, "R1 timeout from done", reinit, 1);
    finish_run();
  end
endmodule